// File: doc/BRIEF.md
# Multichannel ADC Frame Capture Sequencer

This block paces an eight-lane serial ADC at a fixed frame rate that comes from the system clock by an integer ratio. With the default 72 MHz clock and a 48 kHz frame rate, each frame is exactly 1500 clock cycles long. At every frame tick it raises the conversion-start line for a fixed number of cycles. It then waits a fixed conversion time. Next it runs a burst of sixteen serial clock periods and shifts one 16-bit result, MSB first, from each of eight parallel data lanes.

When the burst is done, the eight results go to a downstream sample FIFO as one frame, in channel order. Each word carries its channel index. The frame is written only if the FIFO reports room for all eight words, so the downstream side never sees part of a frame. A frame that does not fit is discarded and counted. A frame tick that arrives while a frame is still in progress is ignored and reported on an overrun strobe.

Every timing constant is a parameter. The derived cycle counts are computed as sized values, so the conversion schedule is exact to the cycle for any legal clock ratio.

Top module: `adc_frame_seq`

## Requirements
- R1: With no overrun, `adc_cnv` rises once every SYS_HZ/FRAME_HZ clock cycles (1500 by default).
- R2: `adc_cnv` stays high for exactly CNV_CYC consecutive cycles per frame (3 by default).
- R3: `adc_sck` is low while `adc_cnv` is high and for WAIT_CYC cycles after it (40 by default). The first rising edge of `adc_sck` comes WAIT_CYC+SCK_HALF cycles after `adc_cnv` falls. Each frame has exactly 16 rising edges, spaced 2*SCK_HALF cycles apart (4 by default, 2 low then 2 high).
- R4: Lane k of `adc_sdata` is bit k and carries channel k. It is sampled at each rising edge of `adc_sck`, and the first sampled bit is the MSB of the 16-bit result.
- R5: An accepted frame is written as 8 words on 8 consecutive cycles with `fifo_wr` high. `fifo_wch` runs 0,1,...,7 and `fifo_wdata` holds that channel's result.
- R6: `fifo_space` is compared against 8 in the last serial clock cycle. A value of 8 or more accepts the frame. A value below 8 gives no write at all for that frame and increments `drop_cnt` by one.
- R7: A frame tick while a frame is in progress gives a one-cycle `overrun` pulse and does not start a frame. The next tick that finds the sequencer idle starts one.
- R8: While reset is held, and until the first tick, `adc_cnv`, `adc_sck`, `fifo_wr` and `overrun` are low and `drop_cnt` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| adc_sdata | input | NUM_CH | Serial data lanes, one per channel |
| fifo_space | input | SPACE_W | Free entries in the downstream FIFO |
| adc_cnv | output | 1 | Conversion start |
| adc_sck | output | 1 | Serial clock to the converter |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wch | output | CH_W | Channel index of the word being written |
| fifo_wdata | output | SAMPLE_W | Sample word being written |
| drop_cnt | output | DROP_W | Count of frames discarded for lack of room (wraps) |
| overrun | output | 1 | One-cycle pulse on a tick that was ignored |

## Verification
A converter model in the bench serves a different 16-bit value on each lane. The frames use distinct per-channel values, alternating 0xAAAA/0x5555 words, walking-one patterns and all-ones/all-zeros. A swapped lane, a reversed bit order or an off-by-one sampling edge each show up as a distinct wrong word. FIFO room of exactly 8 and of 7 separates the accept threshold from the drop path. A large free count checks that back-to-back frames keep the exact 1500-cycle spacing. A second instance, whose conversion wait is longer than a frame, checks that a busy-time tick is flagged and skipped and that the following tick starts normally.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CNV   = 3'd1,
    ST_WAIT  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_WRITE = 3'd4
  } seq_state_t;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int unsigned FRAME_CYC = 1500
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned TW = (FRAME_CYC > 1) ? $clog2(FRAME_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(FRAME_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);

  // R1
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/adc_lane_capture.sv
module adc_lane_capture #(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned CH_W     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic [NUM_CH-1:0]   sdata,
  input  logic [CH_W-1:0]     rd_ch,
  output logic [SAMPLE_W-1:0] rd_data
);
  logic [SAMPLE_W-1:0] lane_q [NUM_CH];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
    logic [SAMPLE_W-1:0] lane_d;
    always_comb begin
      lane_d = lane_q[k];
      if (shift_en) lane_d = {lane_q[k][SAMPLE_W-2:0], sdata[k]};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q[k] <= '0;
      else        lane_q[k] <= lane_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_ch == CH_W'(i)) rd_data = lane_q[i];
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned CNV_CYC  = 3,
  parameter int unsigned WAIT_CYC = 40,
  parameter int unsigned SCK_HALF = 2,
  parameter int unsigned SPACE_W  = 6,
  parameter int unsigned DROP_W   = 16,
  parameter int unsigned CH_W     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic [SPACE_W-1:0] fifo_space_i,
  output logic               cnv_o,
  output logic               sck_o,
  output logic               shift_en_o,
  output logic               wr_o,
  output logic [CH_W-1:0]    wch_o,
  output logic [DROP_W-1:0]  drop_cnt_o,
  output logic               overrun_o
);
  localparam int unsigned PER  = 2 * SCK_HALF;
  localparam int unsigned M1   = (CNV_CYC > WAIT_CYC) ? CNV_CYC : WAIT_CYC;
  localparam int unsigned MAXC = (M1 > PER) ? M1 : PER;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam int unsigned BW   = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;
  localparam logic [CW-1:0]   CNV_LAST  = CW'(CNV_CYC - 1);
  localparam logic [CW-1:0]   WAIT_LAST = CW'(WAIT_CYC - 1);
  localparam logic [CW-1:0]   PER_LAST  = CW'(PER - 1);
  localparam logic [CW-1:0]   HALF_C    = CW'(SCK_HALF);
  localparam logic [CW-1:0]   HALF_LAST = CW'(SCK_HALF - 1);
  localparam logic [BW-1:0]   BIT_LAST  = BW'(SAMPLE_W - 1);
  localparam logic [CH_W-1:0] CH_LAST   = CH_W'(NUM_CH - 1);
  localparam logic [SPACE_W-1:0] NEED   = SPACE_W'(NUM_CH);

  seq_state_t        state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic [DROP_W-1:0] drop_q, drop_d;
  logic              cnv_q, sck_q, ovr_q;
  logic              space_ok, drop_inc;

  assign space_ok = (fifo_space_i >= NEED);

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    bit_d    = bit_q;
    ch_d     = ch_q;
    drop_inc = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tick_i) begin
          state_d = ST_CNV;
          cnt_d   = '0;
        end
      end
      ST_CNV: begin
        if (cnt_q == CNV_LAST) begin
          state_d = ST_WAIT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (cnt_q == WAIT_LAST) begin
          state_d = ST_SHIFT;
          cnt_d   = '0;
          bit_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (cnt_q == PER_LAST) begin
          cnt_d = '0;
          if (bit_q == BIT_LAST) begin
            if (space_ok) begin
              state_d = ST_WRITE;
              ch_d    = '0;
            end else begin
              state_d  = ST_IDLE;
              drop_inc = 1'b1;
            end
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WRITE: begin
        if (ch_q == CH_LAST) state_d = ST_IDLE;
        else                 ch_d = ch_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    drop_d = drop_inc ? (drop_q + 1'b1) : drop_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      ch_q    <= '0;
      drop_q  <= '0;
      cnv_q   <= 1'b0;
      sck_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      ch_q    <= ch_d;
      drop_q  <= drop_d;
      cnv_q   <= (state_d == ST_CNV);
      sck_q   <= (state_d == ST_SHIFT) && (cnt_d >= HALF_C);
      ovr_q   <= tick_i && (state_q != ST_IDLE);
    end
  end

  assign cnv_o      = cnv_q;
  assign sck_o      = sck_q;
  assign shift_en_o = (state_q == ST_SHIFT) && (cnt_q == HALF_LAST);
  assign wr_o       = (state_q == ST_WRITE);
  assign wch_o      = ch_q;
  assign drop_cnt_o = drop_q;
  assign overrun_o  = ovr_q;

  // R4
  sample_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en_o |=> sck_o);
  // R3
  sck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o |-> !sck_o && !wr_o);
  // R5
  first_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && !$past(wr_o)) |-> (wch_o == '0));
  // R5
  ch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && $past(wr_o)) |-> (wch_o == $past(wch_o) + 1'b1));
  // R6
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q != $past(drop_q)) |-> ($past(fifo_space_i) < NEED));
  // R7
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> ($past(tick_i) && !$rose(cnv_o)));
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq #(
  parameter int unsigned SYS_HZ   = 72_000_000,
  parameter int unsigned FRAME_HZ = 48_000,
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned CNV_CYC  = 3,
  parameter int unsigned WAIT_CYC = 40,
  parameter int unsigned SCK_HALF = 2,
  parameter int unsigned SPACE_W  = 6,
  parameter int unsigned DROP_W   = 16,
  parameter int unsigned CH_W     = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   adc_sdata,
  input  logic [SPACE_W-1:0]  fifo_space,
  output logic                adc_cnv,
  output logic                adc_sck,
  output logic                fifo_wr,
  output logic [CH_W-1:0]     fifo_wch,
  output logic [SAMPLE_W-1:0] fifo_wdata,
  output logic [DROP_W-1:0]   drop_cnt,
  output logic                overrun
);
  localparam int unsigned FRAME_CYC = SYS_HZ / FRAME_HZ;

  logic [1:0] rst_sync_q;
  logic       rst_ns;
  logic       tick;
  logic       shift_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  adc_tick_gen #(.FRAME_CYC(FRAME_CYC)) u_tick (
    .clk   (clk),
    .rst_n (rst_ns),
    .tick_o(tick)
  );

  adc_seq_ctrl #(
    .NUM_CH  (NUM_CH),
    .SAMPLE_W(SAMPLE_W),
    .CNV_CYC (CNV_CYC),
    .WAIT_CYC(WAIT_CYC),
    .SCK_HALF(SCK_HALF),
    .SPACE_W (SPACE_W),
    .DROP_W  (DROP_W),
    .CH_W    (CH_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_ns),
    .tick_i      (tick),
    .fifo_space_i(fifo_space),
    .cnv_o       (adc_cnv),
    .sck_o       (adc_sck),
    .shift_en_o  (shift_en),
    .wr_o        (fifo_wr),
    .wch_o       (fifo_wch),
    .drop_cnt_o  (drop_cnt),
    .overrun_o   (overrun)
  );

  adc_lane_capture #(
    .NUM_CH  (NUM_CH),
    .SAMPLE_W(SAMPLE_W),
    .CH_W    (CH_W)
  ) u_capture (
    .clk     (clk),
    .rst_n   (rst_ns),
    .shift_en(shift_en),
    .sdata   (adc_sdata),
    .rd_ch   (fifo_wch),
    .rd_data (fifo_wdata)
  );
endmodule

// File: tb/adc_frame_seq_bench.sv
module adc_frame_seq_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [7:0]  sdata;
  logic [5:0]  space;
  logic        adc_cnv, adc_sck, fifo_wr, overrun;
  logic [2:0]  fifo_wch;
  logic [15:0] fifo_wdata;
  logic [15:0] drop_cnt;

  logic        o_cnv, o_sck, o_wr, o_ovr;
  logic [2:0]  o_wch;
  logic [15:0] o_wdata, o_drop;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int unsigned cyc = 0;
  int unsigned last_rise = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // converter model
  logic [15:0] mvals [8];
  int bitidx = 15;
  always @(posedge adc_cnv) bitidx = 15;
  always @(negedge adc_sck) if (bitidx > 0) bitidx = bitidx - 1;
  always @* for (int k = 0; k < 8; k++) sdata[k] = mvals[k][bitidx[3:0]];

  adc_frame_seq u_adc_frame_seq (
    .clk(clk), .rst_n(rst_n), .adc_sdata(sdata), .fifo_space(space),
    .adc_cnv(adc_cnv), .adc_sck(adc_sck), .fifo_wr(fifo_wr),
    .fifo_wch(fifo_wch), .fifo_wdata(fifo_wdata), .drop_cnt(drop_cnt),
    .overrun(overrun));

  adc_frame_seq #(.WAIT_CYC(1500)) u_adc_frame_seq_ovr (
    .clk(clk), .rst_n(rst_n), .adc_sdata(8'h00), .fifo_space(6'd8),
    .adc_cnv(o_cnv), .adc_sck(o_sck), .fifo_wr(o_wr),
    .fifo_wch(o_wch), .fifo_wdata(o_wdata), .drop_cnt(o_drop),
    .overrun(o_ovr));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    space = 6'd20;
    for (int k = 0; k < 8; k++) mvals[k] = 16'h0;
    repeat (5) @(negedge clk);
    chk(!adc_cnv && !adc_sck && !fifo_wr && !overrun, "R8", "outputs in reset",
        {adc_cnv, adc_sck, fifo_wr, overrun}, 0);
    chk(drop_cnt == 0, "R8", "drop_cnt in reset", drop_cnt, 0);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    chk(!adc_cnv && !adc_sck && !fifo_wr && !overrun, "R8", "outputs before tick",
        {adc_cnv, adc_sck, fifo_wr, overrun}, 0);
  endtask

  task automatic do_frame(input logic [127:0] vals, input int sp, input bit chk_period);
    logic pc;
    int n_cnv, n_rise, first_rise, last_sck, wn, first_wr, cnv_fall;
    logic ps;
    logic [15:0] d0;
    for (int k = 0; k < 8; k++) mvals[k] = vals[16*k +: 16];
    space = sp[5:0];
    pc = adc_cnv;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (adc_cnv && !pc) break;
      pc = adc_cnv;
    end
    if (chk_period)
      chk(cyc - last_rise == 1500, "R1", "frame spacing", cyc - last_rise, 1500);
    last_rise = cyc;
    d0 = drop_cnt;
    n_cnv = 0; n_rise = 0; first_rise = -1; last_sck = -1;
    wn = 0; first_wr = -1; cnv_fall = -1; ps = 1'b0;
    for (int n = 0; n < 1500; n++) begin
      if (n > 0) @(negedge clk);
      if (adc_cnv) n_cnv++;
      else if (cnv_fall < 0) cnv_fall = n;
      if (adc_sck && !ps) begin
        n_rise++;
        if (first_rise < 0) first_rise = n;
        else if (n - last_sck != 4)
          chk(0, "R3", "sck period", n - last_sck, 4);
        last_sck = n;
      end
      ps = adc_sck;
      if (fifo_wr) begin
        if (first_wr < 0) first_wr = n;
        if (wn < 8) begin
          chk(fifo_wch == wn[2:0], "R5", "channel index", fifo_wch, wn);
          chk(fifo_wdata == vals[16*wn +: 16], "R4", "sample word", fifo_wdata,
              vals[16*wn +: 16]);
          chk(n == first_wr + wn, "R5", "consecutive write", n, first_wr + wn);
        end
        wn++;
      end
    end
    chk(n_cnv == 3, "R2", "cnv width", n_cnv, 3);
    chk(cnv_fall == 3, "R2", "cnv fall", cnv_fall, 3);
    chk(n_rise == 16, "R3", "sck rises", n_rise, 16);
    chk(first_rise - cnv_fall == 42, "R3", "first sck rise after cnv fall",
        first_rise - cnv_fall, 42);
    if (sp >= 8) begin
      chk(wn == 8, "R5", "words written", wn, 8);
      chk(drop_cnt == d0, "R6", "drop unchanged", drop_cnt, d0);
    end else begin
      chk(wn == 0, "R6", "words on drop", wn, 0);
      chk(drop_cnt == d0 + 16'd1, "R6", "drop increment", drop_cnt, d0 + 16'd1);
    end
  endtask

  task automatic t_overrun();
    logic pc;
    int n_ovr, n_cnv_rise;
    pc = o_cnv;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      if (o_cnv && !pc) break;
      pc = o_cnv;
    end
    n_ovr = 0; n_cnv_rise = 0; pc = o_cnv;
    for (int n = 1; n < 3000; n++) begin
      @(negedge clk);
      if (o_ovr) n_ovr++;
      if (o_cnv && !pc) n_cnv_rise++;
      pc = o_cnv;
    end
    chk(n_ovr == 1, "R7", "overrun pulses", n_ovr, 1);
    chk(n_cnv_rise == 0, "R7", "busy tick started frame", n_cnv_rise, 0);
    @(negedge clk);
    chk(o_cnv && !pc, "R7", "next idle tick starts frame", o_cnv, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    logic [127:0] v;
    t_reset();
    // distinct values per channel, ample room
    v = {16'h8001, 16'h7FFE, 16'h1357, 16'h2468, 16'hBEEF, 16'hCAFE, 16'h0F0F, 16'h1234};
    do_frame(v, 20, 1'b0);
    // alternating bits, room exactly 8
    v = {4{16'h5555, 16'hAAAA}};
    do_frame(v, 8, 1'b1);
    // room 7: frame dropped
    v = {8{16'hFFFF}};
    do_frame(v, 7, 1'b1);
    // walking one
    for (int k = 0; k < 8; k++) v[16*k +: 16] = 16'h0001 << (2 * k + 1);
    do_frame(v, 63, 1'b1);
    // all ones / all zeros mix
    v = {16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF};
    do_frame(v, 8, 1'b1);
    t_overrun();
    finish_run();
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule